// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the hazard controller of a five-stage in-order integer pipeline whose stages, in order, are fetch, decode with register read, execute, memory access and writeback. Each cycle it looks at the register numbers, write enables and instruction flags sitting in the pipeline registers. From them it produces the steering and hold signals that let a new instruction enter every cycle whenever no hazard prevents it. The datapath, ALU, memories and branch-target logic are outside this block; they only consume its outputs.

Three mechanisms are combined. The first is result bypassing into both execute-stage operands, taken from the memory stage or the writeback stage, with a matching bypass in decode for a register being written back in the same cycle. The second is a one-cycle interlock when a load in execute feeds the instruction in decode. The third is a branch policy with no prediction and no delay slot: each conditional branch costs two hold cycles after it leaves decode. A hold freezes the program counter and the fetch/decode register while a no-operation is written into the decode/execute register. Every pin is a plain control pin. No data streams through the block, so it has no valid/ready handshake and exerts no back-pressure.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the block clears its branch bubble state. With no load hazard present, `pc_hold`, `ifid_hold` and `idex_bubble` are all 0.
- R2: An execute operand selects code 2'b10 (memory stage) when the memory-stage destination equals that operand's source, the memory-stage write enable is 1 and the register is not 0.
- R3: An execute operand selects code 2'b01 (writeback stage) when only the writeback-stage destination matches under the same conditions.
- R4: When both the memory stage and the writeback stage match an operand, the memory-stage code 2'b10 wins.
- R5: With no enabled matching destination, an execute operand selects code 2'b00 (register file).
- R6: Register 0 never causes a bypass, a decode bypass or a hold.
- R7: A load in execute (load flag and write enable both 1) whose destination matches either decode source drives `pc_hold`, `ifid_hold` and `idex_bubble` to 1 in that same cycle. When the load moves on the next cycle, the hold drops.
- R8: A non-load producer in execute never causes a hold, whatever the register overlap.
- R9: `id_wb_byp_a`/`id_wb_byp_b` are 1 when the enabled writeback destination equals decode source 1/2, so that value is taken in the same cycle.
- R10: In the cycle a branch leaves decode (branch flag 1, no hold), no hold is shown. The hold signals are then 1 for exactly the next two cycles and 0 in the cycle after those.
- R11: When a branch in decode meets a load-use hazard, the one-cycle load hold comes first. The two branch hold cycles start only after the branch leaves decode.
- R12: A branch flag that is present during a branch hold window neither extends nor restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_AW | Decode source register 1 |
| id_rs2 | input | REG_AW | Decode source register 2 |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| ex_rs1 | input | REG_AW | Execute source register 1 |
| ex_rs2 | input | REG_AW | Execute source register 2 |
| ex_rd | input | REG_AW | Execute destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_AW | Writeback destination register |
| wb_wen | input | 1 | Writeback instruction writes a register |
| ex_fwd_a | output | 2 | Execute operand 1 select: 00 register file, 01 writeback, 10 memory |
| ex_fwd_b | output | 2 | Execute operand 2 select, same codes |
| id_wb_byp_a | output | 1 | Decode operand 1 takes the writeback value |
| id_wb_byp_b | output | 1 | Decode operand 2 takes the writeback value |
| pc_hold | output | 1 | Freeze program counter |
| ifid_hold | output | 1 | Freeze fetch/decode register |
| idex_bubble | output | 1 | Write a no-operation into decode/execute register |

## Verification
The bypass selects, the decode bypass and the load-use hold are combinational, so they are due in the same cycle as the stimulus. The bench sweeps every combination of register numbers and enables for a 3-bit register address and samples a few nanoseconds after each input change. Branch bubbles come from a counter loaded at the clock edge on which the branch leaves decode. Their holds are therefore due in the first and second cycles after that edge and are gone in the third. The bench changes inputs just after each rising edge and samples mid-cycle, so each check sees the counter value set at the preceding edge.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  typedef enum logic [1:0] {
    BYP_RF  = 2'b00,
    BYP_WB  = 2'b01,
    BYP_MEM = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import pipe_hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output byp_sel_e          sel
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = mem_wen && (mem_rd != '0) && (mem_rd == src);
    wb_hit  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);
    if (mem_hit)     sel = BYP_MEM;
    else if (wb_hit) sel = BYP_WB;
    else             sel = BYP_RF;
  end

  // R6: register zero never steers an operand away from the file
  assert_zero_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == BYP_RF));

  // R4: both later stages matching resolves to the memory stage
  assert_mem_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && wb_wen && src != '0 && mem_rd == src && wb_rd == src) |-> (sel == BYP_MEM));

  // R5: no enabled writer means the register file is used
  assert_idle_rf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wen && !wb_wen) |-> (sel == BYP_RF));
endmodule

// File: rtl/hz_id_bypass.sv
module hz_id_bypass #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic              take_wb
);
  always_comb take_wb = wb_wen && (wb_rd != '0) && (wb_rd == src);

  // R9 / R6: no bypass without an enabled writer or for register zero
  assert_idbyp_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_wen || src == '0) |-> !take_wb);
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl #(
  parameter int REG_AW     = 5,
  parameter int BR_BUBBLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_is_branch,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble
);
  localparam int CW = $clog2(BR_BUBBLES + 1);

  logic [CW-1:0] br_cnt;
  logic          load_use, br_window, stall, br_leave;

  always_comb begin
    load_use  = ex_is_load && ex_wen && (ex_rd != '0) &&
                ((ex_rd == id_rs1) || (ex_rd == id_rs2));
    br_window = (br_cnt != '0);
    stall     = load_use || br_window;
    br_leave  = id_is_branch && !stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         br_cnt <= '0;
    else if (br_leave)  br_cnt <= CW'(BR_BUBBLES);
    else if (br_window) br_cnt <= br_cnt - 1'b1;
  end

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  // R10: a branch that leaves decode is followed by a hold cycle
  assert_branch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_branch && !pc_hold) |=> pc_hold);

  // R10: the window never exceeds its configured length
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    br_cnt <= CW'(BR_BUBBLES));

  // R12: the last window cycle is always followed by a free counter
  assert_window_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (br_cnt == CW'(1)) |=> (br_cnt == '0));

  // R6: a destination of zero outside a branch window never holds
  assert_zero_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0 && br_cnt == '0) |-> !pc_hold);
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import pipe_hazard_pkg::*;
#(
  parameter int REG_AW     = 5,
  parameter int BR_BUBBLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_is_branch,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic [1:0]        ex_fwd_a,
  output logic [1:0]        ex_fwd_b,
  output logic              id_wb_byp_a,
  output logic              id_wb_byp_b,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble
);
  localparam int NOPS = 2;

  logic [REG_AW-1:0] ex_src [NOPS];
  logic [REG_AW-1:0] id_src [NOPS];
  byp_sel_e          fwd_sel[NOPS];
  logic              id_take[NOPS];

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;
  assign id_src[0] = id_rs1;
  assign id_src[1] = id_rs2;

  for (genvar i = 0; i < NOPS; i++) begin : g_opnd
    hz_fwd_sel #(.REG_AW(REG_AW)) u_fwd (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (ex_src[i]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (fwd_sel[i])
    );
    hz_id_bypass #(.REG_AW(REG_AW)) u_idb (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (id_src[i]),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .take_wb (id_take[i])
    );
  end

  assign ex_fwd_a    = fwd_sel[0];
  assign ex_fwd_b    = fwd_sel[1];
  assign id_wb_byp_a = id_take[0];
  assign id_wb_byp_b = id_take[1];

  hz_stall_ctl #(.REG_AW(REG_AW), .BR_BUBBLES(BR_BUBBLES)) u_stall (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_is_branch (id_is_branch),
    .ex_rd        (ex_rd),
    .ex_wen       (ex_wen),
    .ex_is_load   (ex_is_load),
    .pc_hold      (pc_hold),
    .ifid_hold    (ifid_hold),
    .idex_bubble  (idex_bubble)
  );

  // R7: all three hold controls move together
  assert_hold_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));

  // R8: without a load in execute, holds only come from a branch window
  assert_noload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_is_load && !$past(id_is_branch) && !$past(pc_hold)) |-> !pc_hold);
endmodule

// File: tb/pipe_hazard_unit_test.sv
module pipe_hazard_unit_test;
  localparam int AW = 3;
  localparam int NR = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] id_rs1 = 0, id_rs2 = 0, ex_rs1 = 0, ex_rs2 = 0, ex_rd = 0, mem_rd = 0, wb_rd = 0;
  logic id_is_branch = 0, ex_wen = 0, ex_is_load = 0, mem_wen = 0, wb_wen = 0;
  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic id_wb_byp_a, id_wb_byp_b, pc_hold, ifid_hold, idex_bubble;

  int checks = 0, errors = 0;
  bit done = 0;

  pipe_hazard_unit #(.REG_AW(AW), .BR_BUBBLES(2)) uut (.*);

  always #5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(int s, int mr, int mw, int wr, int ww);
    if (mw != 0 && mr != 0 && mr == s) return 2;
    if (ww != 0 && wr != 0 && wr == s) return 1;
    return 0;
  endfunction

  function automatic int holds();
    return {29'd0, pc_hold, ifid_hold, idex_bubble};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(posedge clk); #2;
    check("R1 hold in reset", holds(), 0);
    check("R1 fwd a in reset", ex_fwd_a, 0);
    step(); rst_n = 1; #2;
    check("R1 hold after release", holds(), 0);

    // R2 R3 R4 R5 R8 R9: exhaustive bypass sweep, non-load producer in execute
    for (int mr = 0; mr < NR; mr++)
      for (int wr = 0; wr < NR; wr++)
        for (int s = 0; s < NR; s++)
          for (int en = 0; en < 4; en++) begin
            mem_rd = AW'(mr); wb_rd = AW'(wr);
            mem_wen = en[0]; wb_wen = en[1];
            ex_rs1 = AW'(s); ex_rs2 = AW'(NR-1-s);
            id_rs1 = AW'(s); id_rs2 = AW'(NR-1-s);
            ex_rd = AW'(s); ex_wen = 1; ex_is_load = 0;
            #2;
            check("R2/R3/R4/R5 fwd a", ex_fwd_a, exp_sel(s, mr, en[0], wr, en[1]));
            check("R2/R3/R4/R5 fwd b", ex_fwd_b, exp_sel(NR-1-s, mr, en[0], wr, en[1]));
            check("R9 id bypass a", id_wb_byp_a, (en[1] && wr != 0 && wr == s) ? 1 : 0);
            check("R9 id bypass b", id_wb_byp_b, (en[1] && wr != 0 && wr == NR-1-s) ? 1 : 0);
            check("R8 no hold non-load", holds(), 0);
          end

    // R6 R7: exhaustive load-use sweep
    mem_wen = 0; wb_wen = 0;
    for (int e = 0; e < NR; e++)
      for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++)
          for (int m = 0; m < 4; m++) begin
            ex_rd = AW'(e); id_rs1 = AW'(a); id_rs2 = AW'(b);
            ex_is_load = m[0]; ex_wen = m[1];
            #2;
            check("R6/R7 load-use hold", holds(),
                  (m[0] && m[1] && e != 0 && (e == a || e == b)) ? 7 : 0);
          end

    // R7: hold drops once the load moves on
    step(); ex_rd = 2; id_rs1 = 2; ex_is_load = 1; ex_wen = 1; #2;
    check("R7 load hold", holds(), 7);
    step(); ex_is_load = 0; ex_wen = 0; #2;
    check("R7 load hold released", holds(), 0);

    ex_rd = 0; id_rs1 = 0; id_rs2 = 0;
    // R10: two bubbles per branch
    step(); id_is_branch = 1; #2;
    check("R10 leave cycle", holds(), 0);
    step(); id_is_branch = 0; #2;
    check("R10 bubble 1", holds(), 7);
    step(); #2;
    check("R10 bubble 2", holds(), 7);
    step(); #2;
    check("R10 window over", holds(), 0);

    // R12: branch flag during window ignored
    step(); id_is_branch = 1; #2;
    check("R12 leave cycle", holds(), 0);
    step(); #2;
    check("R12 bubble 1", holds(), 7);
    step(); #2;
    check("R12 bubble 2", holds(), 7);
    step(); id_is_branch = 0; #2;
    check("R12 not extended", holds(), 0);

    // R11: load hold first, then branch bubbles
    step(); id_is_branch = 1; ex_is_load = 1; ex_wen = 1; ex_rd = 3; id_rs1 = 3; #2;
    check("R11 load hold first", holds(), 7);
    step(); ex_is_load = 0; ex_wen = 0; #2;
    check("R11 branch leaves", holds(), 0);
    step(); id_is_branch = 0; #2;
    check("R11 bubble 1", holds(), 7);
    step(); #2;
    check("R11 bubble 2", holds(), 7);
    step(); #2;
    check("R11 window over", holds(), 0);

    // R1: reset during a branch window clears it
    ex_rd = 0; id_rs1 = 0;
    step(); id_is_branch = 1;
    step(); id_is_branch = 0; #2;
    check("R1 window before reset", holds(), 7);
    rst_n = 0; #1;
    check("R1 reset clears window", holds(), 0);
    step(); rst_n = 1; #2;
    check("R1 clear after reset", holds(), 0);

    step();
    finish_run();
  end
endmodule